// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This block sits beside a host memory controller and takes a pseudo-static RAM into and out of its deep power-down state. Entry has two separate steps. An arm request makes the block issue one configuration-register write with the power-down enable bit set. After that, ordinary traffic may continue. A later sleep request lowers the active-low sleep pin. Before the pin falls, the block forces chip select inactive for a set time. It then holds the pin low for at least the minimum time the memory requires.

Releasing the sleep request raises the sleep pin. A recovery window follows. During that window the block forces chip select inactive, so only deselect reaches the memory, and it holds its busy output high. When the window ends, the block pulses ready and returns to idle. All minimum intervals are set in nanoseconds and converted to clock cycles, rounded up, from the clock frequency parameter. A sleep request that arrives before arming is rejected with a one-cycle error pulse.

Top module: `dpd_seq`

## Requirements
- R1: While rst_ni is low, and right after it is released: mem_zz_n_o is high, and busy_o, armed_o, dpd_ack_o, cfg_wr_req_o, ready_o and contents_lost_o are all low.
- R2: In idle, arm_req_i raises cfg_wr_req_o. The request holds until cfg_wr_ack_i, with cfg_wr_data_o equal to CFG_BASE with bit DPD_BIT set (default 16'h0010). mem_zz_n_o stays high throughout. armed_o rises after the acknowledge. An arm request while already armed issues no further write.
- R3: A rising dpd_req_i while not armed gives err_o high for exactly one cycle. mem_zz_n_o stays high and the block does not arm.
- R4: While armed, and before the sleep step, mem_cs_n_o follows mc_cs_n_i and busy_o is low.
- R5: mem_zz_n_o falls only after at least the precharge count of cycles since the arm write ended, and after at least the setup count of cycles in which mem_cs_n_o was forced high.
- R6: Once mem_zz_n_o falls, it stays low for at least the minimum-low count of cycles, even if dpd_req_i drops earlier. mem_cs_n_o stays high throughout.
- R7: While dpd_req_i stays high after the minimum-low time, dpd_ack_o is high and the pin stays low. Dropping dpd_req_i raises mem_zz_n_o within one cycle once the minimum is met.
- R8: After mem_zz_n_o rises, the recovery count of cycles pass with busy_o high and mem_cs_n_o forced high. Then ready_o pulses for one cycle and the block returns to idle, unarmed, with chip select passed through again.
- R9: contents_lost_o rises when mem_zz_n_o rises on exit. It stays high until the acknowledge of the next arm write.
- R10: Each interval in cycles is ceil(ns × CLK_FREQ_HZ / 1e9), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_req_i | input | 1 | Request to arm power-down through a configuration write |
| dpd_req_i | input | 1 | Level request: high to sleep, low to wake |
| dpd_ack_o | output | 1 | Memory is held in power-down |
| ready_o | output | 1 | One-cycle pulse when recovery completes |
| err_o | output | 1 | One-cycle pulse when a sleep request arrives while not armed |
| armed_o | output | 1 | Power-down enable bit has been written |
| busy_o | output | 1 | Memory controller must withhold all commands |
| contents_lost_o | output | 1 | Memory contents were lost by a power-down |
| cfg_wr_req_o | output | 1 | Configuration-register write request |
| cfg_wr_data_o | output | CFG_W | Configuration value to write |
| cfg_wr_ack_i | input | 1 | Configuration write completed |
| mc_cs_n_i | input | 1 | Chip select from the memory controller, active low |
| mem_cs_n_o | output | 1 | Chip select to the memory, active low |
| mem_zz_n_o | output | 1 | Sleep pin to the memory, active low |

## Verification
The assertions assume that cfg_wr_ack_i arrives only while cfg_wr_req_o is high. They also assume that the memory controller honours busy_o, so mc_cs_n_i has no effect on the pin while busy_o is high. The stimulus gives one acknowledge, on the cycle after the write request is seen. It drives mc_cs_n_i low on purpose during setup, power-down and recovery, so the forcing of chip select is actually exercised. dpd_req_i changes only at falling edges. It is dropped at several points: before, at and after the end of the minimum-low interval.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM_WR,
    ST_ARMED,
    ST_CS_SETUP,
    ST_ZZ_MIN,
    ST_IN_DPD,
    ST_RECOVER,
    ST_READY
  } dpd_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int ns_to_cycles(input int ns, input int hz);
    longint prod;
    longint cyc;
    prod = longint'(ns) * longint'(hz);
    cyc  = (prod + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dpd_interval_timer.sv
module dpd_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  // state entered with count N lasts N cycles when left on done
  assign done_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/dpd_cmd_gate.sv
module dpd_cmd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic mc_cs_n_i,
  output logic mem_cs_n_o
);

  assign mem_cs_n_o = block_i | mc_cs_n_i;

  a_r8_blocked_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |-> mem_cs_n_o);

endmodule

// File: rtl/dpd_fsm.sv
module dpd_fsm
  import dpd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRE_CYC = 1,
  parameter int SET_CYC = 1,
  parameter int ZZ_CYC  = 1,
  parameter int REC_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_req_i,
  input  logic             dpd_req_i,
  input  logic             cfg_wr_ack_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             cfg_wr_req_o,
  output logic             zz_n_o,
  output logic             block_o,
  output logic             armed_o,
  output logic             dpd_ack_o,
  output logic             ready_o,
  output logic             err_o,
  output logic             lost_o
);

  dpd_state_e state_q, state_d;
  logic       armed_q, req_q, err_q, lost_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (arm_req_i)               state_d = ST_ARM_WR;
      ST_ARM_WR:   if (cfg_wr_ack_i)            state_d = ST_ARMED;
      ST_ARMED:    if (dpd_req_i && tmr_done_i) state_d = ST_CS_SETUP;
      ST_CS_SETUP: if (tmr_done_i)              state_d = ST_ZZ_MIN;
      ST_ZZ_MIN:   if (tmr_done_i)              state_d = ST_IN_DPD;
      ST_IN_DPD:   if (!dpd_req_i)              state_d = ST_RECOVER;
      ST_RECOVER:  if (tmr_done_i)              state_d = ST_READY;
      ST_READY:                                 state_d = ST_IDLE;
      default:                                  state_d = ST_IDLE;
    endcase
  end

  assign tmr_load_o = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_ARMED:    tmr_val_o = CNT_W'(PRE_CYC);
      ST_CS_SETUP: tmr_val_o = CNT_W'(SET_CYC);
      ST_ZZ_MIN:   tmr_val_o = CNT_W'(ZZ_CYC);
      ST_RECOVER:  tmr_val_o = CNT_W'(REC_CYC);
      default:     tmr_val_o = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= dpd_req_i;
      err_q   <= (state_q == ST_IDLE) && dpd_req_i && !req_q;
      if (state_q == ST_ARM_WR && cfg_wr_ack_i)    armed_q <= 1'b1;
      else if (state_q == ST_READY)                armed_q <= 1'b0;
      if (state_q == ST_IN_DPD && !dpd_req_i)      lost_q  <= 1'b1;
      else if (state_q == ST_ARM_WR && cfg_wr_ack_i) lost_q <= 1'b0;
    end
  end

  assign cfg_wr_req_o = (state_q == ST_ARM_WR);
  assign zz_n_o       = !(state_q == ST_ZZ_MIN || state_q == ST_IN_DPD);
  assign block_o      = (state_q == ST_CS_SETUP) || (state_q == ST_ZZ_MIN) ||
                        (state_q == ST_IN_DPD)   || (state_q == ST_RECOVER);
  assign armed_o      = armed_q;
  assign dpd_ack_o    = (state_q == ST_IN_DPD);
  assign ready_o      = (state_q == ST_READY);
  assign err_o        = err_q;
  assign lost_o       = lost_q;

  a_r3_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r2_arm_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(cfg_wr_ack_i));

endmodule

// File: rtl/dpd_seq.sv
module dpd_seq #(
  parameter int          CLK_FREQ_HZ = 100_000_000,
  parameter int          T_SETUP_NS  = 5,
  parameter int          T_PRECH_NS  = 5,
  parameter int          T_ZZ_MIN_NS = 10_000,
  parameter int          T_RECOV_NS  = 150_000,
  parameter int          CFG_W       = 16,
  parameter int          DPD_BIT     = 4,
  parameter logic [15:0] CFG_BASE    = 16'h0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_req_i,
  input  logic             dpd_req_i,
  output logic             dpd_ack_o,
  output logic             ready_o,
  output logic             err_o,
  output logic             armed_o,
  output logic             busy_o,
  output logic             contents_lost_o,
  output logic             cfg_wr_req_o,
  output logic [CFG_W-1:0] cfg_wr_data_o,
  input  logic             cfg_wr_ack_i,
  input  logic             mc_cs_n_i,
  output logic             mem_cs_n_o,
  output logic             mem_zz_n_o
);

  localparam int SET_CYC = dpd_pkg::ns_to_cycles(T_SETUP_NS,  CLK_FREQ_HZ);
  localparam int PRE_CYC = dpd_pkg::ns_to_cycles(T_PRECH_NS,  CLK_FREQ_HZ);
  localparam int ZZ_CYC  = dpd_pkg::ns_to_cycles(T_ZZ_MIN_NS, CLK_FREQ_HZ);
  localparam int REC_CYC = dpd_pkg::ns_to_cycles(T_RECOV_NS,  CLK_FREQ_HZ);
  localparam int MAX_CYC = dpd_pkg::max4(SET_CYC, PRE_CYC, ZZ_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CFG_W-1:0] CFG_ARM = CFG_W'(CFG_BASE) | (CFG_W'(1) << DPD_BIT);

  logic             tmr_load, tmr_done, block;
  logic [CNT_W-1:0] tmr_val;

  dpd_fsm #(
    .CNT_W  (CNT_W),
    .PRE_CYC(PRE_CYC),
    .SET_CYC(SET_CYC),
    .ZZ_CYC (ZZ_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_req_i   (arm_req_i),
    .dpd_req_i   (dpd_req_i),
    .cfg_wr_ack_i(cfg_wr_ack_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cfg_wr_req_o(cfg_wr_req_o),
    .zz_n_o      (mem_zz_n_o),
    .block_o     (block),
    .armed_o     (armed_o),
    .dpd_ack_o   (dpd_ack_o),
    .ready_o     (ready_o),
    .err_o       (err_o),
    .lost_o      (contents_lost_o)
  );

  dpd_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  dpd_cmd_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .block_i   (block),
    .mc_cs_n_i (mc_cs_n_i),
    .mem_cs_n_o(mem_cs_n_o)
  );

  assign busy_o        = block;
  assign cfg_wr_data_o = CFG_ARM;

  // interval checkers: saturating run-length counters on the sleep pin
  logic [CNT_W-1:0] low_run_q, high_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= '0;
    end else begin
      if (!mem_zz_n_o) low_run_q <= (low_run_q < CNT_W'(ZZ_CYC)) ? low_run_q + 1'b1 : low_run_q;
      else             low_run_q <= '0;
      if (mem_zz_n_o)  high_run_q <= (high_run_q < CNT_W'(REC_CYC)) ? high_run_q + 1'b1 : high_run_q;
      else             high_run_q <= '0;
    end
  end

  a_r6_cs_high_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_zz_n_o |-> mem_cs_n_o);
  a_r5_cs_before_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_zz_n_o) |-> $past(mem_cs_n_o));
  a_r6_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_zz_n_o) |-> (low_run_q >= CNT_W'(ZZ_CYC)));
  a_r8_recovery_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (high_run_q >= CNT_W'(REC_CYC)));
  a_r8_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> mem_cs_n_o);
  a_r2_cfg_pin_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_req_o |-> mem_zz_n_o);
  a_r3_err_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mem_zz_n_o && !armed_o));
  a_r9_lost_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_zz_n_o) |-> contents_lost_o);
  a_r7_ack_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dpd_ack_o, ready_o, err_o, cfg_wr_req_o}));

endmodule

// File: tb/dpd_seq_tb.sv
module dpd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ       = 1_300_000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_req = 1'b0, dpd_req = 1'b0, cfg_ack = 1'b0, mc_cs_n = 1'b1;
  logic        dpd_ack_o, ready_o, err_o, armed_o, busy_o, contents_lost_o;
  logic        cfg_wr_req_o, mem_cs_n_o, mem_zz_n_o;
  logic [15:0] cfg_wr_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpd_seq #(.CLK_FREQ_HZ(FREQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .arm_req_i(arm_req), .dpd_req_i(dpd_req),
    .dpd_ack_o(dpd_ack_o), .ready_o(ready_o), .err_o(err_o), .armed_o(armed_o),
    .busy_o(busy_o), .contents_lost_o(contents_lost_o), .cfg_wr_req_o(cfg_wr_req_o),
    .cfg_wr_data_o(cfg_wr_data_o), .cfg_wr_ack_i(cfg_ack), .mc_cs_n_i(mc_cs_n),
    .mem_cs_n_o(mem_cs_n_o), .mem_zz_n_o(mem_zz_n_o)
  );

  int checks = 0, errors = 0;
  int set_c, pre_c, zz_c, rec_c;
  bit lost_exp = 1'b0;

  // scenario table: arm first?, cycles to hold the request after the pin falls
  localparam int N_VEC = 4;
  localparam bit VEC_ARM  [N_VEC] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam int VEC_HOLD [N_VEC] = '{1, 0, 40, 14};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_arm();
    @(negedge clk); arm_req = 1'b1;
    @(negedge clk); arm_req = 1'b0;
    chk(cfg_wr_req_o, "R2 write request", int'(cfg_wr_req_o), 1);
    chk(cfg_wr_data_o == 16'h0010, "R2 write data", int'(cfg_wr_data_o), 16'h0010);
    chk(mem_zz_n_o, "R2 pin high during write", int'(mem_zz_n_o), 1);
    @(negedge clk);
    chk(cfg_wr_req_o, "R2 request held until ack", int'(cfg_wr_req_o), 1);
    chk(contents_lost_o == lost_exp, "R9 flag before ack", int'(contents_lost_o), int'(lost_exp));
    cfg_ack = 1'b1;
    @(negedge clk); cfg_ack = 1'b0;
    lost_exp = 1'b0;
    chk(armed_o && !cfg_wr_req_o, "R2 armed after ack", int'(armed_o), 1);
    chk(!contents_lost_o, "R9 cleared by arm ack", int'(contents_lost_o), 0);
  endtask

  task automatic run_scn(input bit arm, input int hold);
    int cs_hi, hi_cnt, low, cs_bad, rec, lo;
    bit ack_seen;
    if (!arm) begin
      @(negedge clk); dpd_req = 1'b1;
      @(negedge clk);
      chk(err_o, "R3 error pulse", int'(err_o), 1);
      @(negedge clk);
      chk(!err_o, "R3 error one cycle", int'(err_o), 0);
      repeat (3) @(negedge clk);
      chk(mem_zz_n_o && !armed_o && !busy_o, "R3 no entry when unarmed", int'(mem_zz_n_o), 1);
      dpd_req = 1'b0;
      @(negedge clk);
      return;
    end
    do_arm();
    // ordinary traffic while armed
    mc_cs_n = 1'b1; @(negedge clk);
    chk(mem_cs_n_o && !busy_o, "R4 pass-through high", int'(mem_cs_n_o), 1);
    mc_cs_n = 1'b0; @(negedge clk);
    chk(!mem_cs_n_o && !busy_o, "R4 pass-through low", int'(mem_cs_n_o), 0);
    arm_req = 1'b1; @(negedge clk); arm_req = 1'b0; @(negedge clk);
    chk(!cfg_wr_req_o && armed_o, "R2 re-arm ignored", int'(cfg_wr_req_o), 0);
    // sleep step; controller keeps trying to select
    dpd_req = 1'b1;
    cs_hi = 0; hi_cnt = 4;
    for (int i = 0; i < 100 && mem_zz_n_o; i++) begin
      @(negedge clk);
      if (mem_zz_n_o) begin
        hi_cnt++;
        cs_hi = mem_cs_n_o ? cs_hi + 1 : 0;
      end
    end
    chk(!mem_zz_n_o, "R5 pin fell", int'(mem_zz_n_o), 0);
    chk(cs_hi >= set_c, "R5 chip-select setup", cs_hi, set_c);
    chk(hi_cnt >= pre_c + set_c, "R5 precharge", hi_cnt, pre_c + set_c);
    low = 1; cs_bad = mem_cs_n_o ? 0 : 1; ack_seen = 1'b0;
    if (low >= hold) dpd_req = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (mem_zz_n_o) break;
      low++;
      if (!mem_cs_n_o) cs_bad++;
      if (dpd_ack_o) ack_seen = 1'b1;
      if (low >= hold) dpd_req = 1'b0;
    end
    lo = (hold > zz_c) ? hold : zz_c;
    chk(low >= zz_c, "R6 minimum low time", low, zz_c);
    chk(low >= lo && low <= lo + 1, "R7 exit after release", low, lo);
    chk(cs_bad == 0, "R6 chip select high while asleep", cs_bad, 0);
    if (hold > zz_c + 1) chk(ack_seen, "R7 ack while held", int'(ack_seen), 1);
    chk(contents_lost_o, "R9 flag on exit", int'(contents_lost_o), 1);
    rec = 0;
    for (int i = 0; i < 5000 && !ready_o; i++) begin
      if (busy_o && mem_cs_n_o) rec++;
      @(negedge clk);
    end
    chk(ready_o, "R8 ready pulse", int'(ready_o), 1);
    chk(rec == rec_c, "R10 recovery cycle count", rec, rec_c);
    @(negedge clk);
    chk(!ready_o && !armed_o && !busy_o && !mem_cs_n_o, "R8 back to idle",
        int'({ready_o, armed_o, busy_o, mem_cs_n_o}), 0);
    lost_exp = 1'b1;
    mc_cs_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    set_c = int'($ceil(5.0      * FREQ / 1.0e9));
    pre_c = int'($ceil(5.0      * FREQ / 1.0e9));
    zz_c  = int'($ceil(10000.0  * FREQ / 1.0e9));
    rec_c = int'($ceil(150000.0 * FREQ / 1.0e9));
    repeat (3) @(negedge clk);
    chk(mem_zz_n_o && !busy_o && !armed_o && !dpd_ack_o && !cfg_wr_req_o && !contents_lost_o,
        "R1 reset state", int'(mem_zz_n_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_zz_n_o && !ready_o && !err_o && mem_cs_n_o, "R1 after release", int'(mem_zz_n_o), 1);

    for (int v = 0; v < N_VEC; v++) run_scn(VEC_ARM[v], VEC_HOLD[v]);

    // reset while asleep
    do_arm();
    dpd_req = 1'b1;
    for (int i = 0; i < 50 && mem_zz_n_o; i++) @(negedge clk);
    chk(!mem_zz_n_o, "R5 entered for reset test", int'(mem_zz_n_o), 0);
    rst_ni = 1'b0;
    #1;
    chk(mem_zz_n_o && !busy_o && !armed_o && !dpd_ack_o && !contents_lost_o,
        "R1 reset during power-down", int'(mem_zz_n_o), 1);
    dpd_req = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_zz_n_o && !armed_o, "R1 idle after reset", int'(armed_o), 0);

    summary();
    $finish;
  end

endmodule